// File: doc/BRIEF.md
# Repeated String Move Engine

This block runs a repeated string operation in hardware over a single synchronous memory port. Software loads a source index, a destination index, an element count, a direction bit, an element size, an operation code, a repeat condition and an accumulator value, then pulses `start`. The engine walks both pointers through memory one element at a time. It can copy elements, compare two strings, or scan a string for the accumulator value. When it finishes it reports the final indexes, the remaining count and the status flags.

Each run spends a fixed setup phase and then a fixed number of cycles per element. The run time is therefore known in advance: `8 + 8*n` cycles for `n` elements. Compare and scan runs can stop early, depending on the zero flag. The memory returns read data one cycle after the request. A word is two bytes, with the low byte at the lower address.

Top module: `rep_str_engine`

## Requirements
- R1: The count is loaded at start. It drops by exactly one for every element processed. The run ends once the count reaches zero, and `cnt_o` then shows the remaining count.
- R2: After each element the indexes step by 1 for bytes (`wide_i`=0) or by 2 for words (`wide_i`=1). They move upward when `dir_i`=0 and downward when `dir_i`=1. A scan steps only the destination index and leaves the source index unchanged.
- R3: Operation code 0 (and code 3) is a move. It reads the element at the source index and writes it to the destination index. A word is stored low byte first. A read and a write are never requested in the same cycle.
- R4: Operation code 1 is a compare. It computes source element minus destination element at the element width and sets the flags from the result: zero, sign, borrow and signed overflow. It never writes memory.
- R5: Operation code 2 is a scan. It computes accumulator minus destination element and sets the same flags; a byte scan uses `acc_i[7:0]`. It issues no source read and no write.
- R6: Repeat code 1 (repeat while equal) ends a compare or scan run after any element that leaves the zero flag clear. Codes 0 and 3 repeat without any condition. A move ignores the repeat code and leaves the flags unchanged.
- R7: Repeat code 2 (repeat while not equal) ends a compare or scan run after any element that leaves the zero flag set. The count and indexes of that element are already updated when the run ends.
- R8: `done` is a one-cycle pulse. It is high in the cycle after the rising edge that lies `8 + 8*k` edges after the edge that sampled `start`, where `k` is the number of elements processed. `busy` is high from the cycle after that sampling edge up to and including the `done` cycle.
- R9: With a count of zero at start, the engine makes no memory access and pulses `done` 8 edges after the start edge.
- R10: `start` has no effect while `busy` is high.
- R11: After reset, `busy`, `done` and all flags are low and no memory request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (sampled when idle) |
| src_idx_i | input | AW | Initial source index |
| dst_idx_i | input | AW | Initial destination index |
| cnt_i | input | CW | Element count |
| dir_i | input | 1 | 0 steps upward, 1 steps downward |
| wide_i | input | 1 | 0 byte elements, 1 word elements |
| op_i | input | 2 | 0/3 move, 1 compare, 2 scan |
| rep_i | input | 2 | 0/3 unconditional, 1 while equal, 2 while not equal |
| acc_i | input | 16 | Accumulator value for scan |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| src_idx_o | output | AW | Current source index |
| dst_idx_o | output | AW | Current destination index |
| cnt_o | output | CW | Current count |
| zf_o | output | 1 | Zero flag |
| sf_o | output | 1 | Sign flag |
| cf_o | output | 1 | Borrow flag |
| of_o | output | 1 | Signed overflow flag |
| mem_rd | output | 1 | Read request |
| mem_wr | output | 1 | Write request |
| mem_wide | output | 1 | Access is a word |
| mem_addr | output | AW | Access address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after `mem_rd` |

## Verification
Each run has one predictable due cycle. `done` is due exactly `8 + 8*k` edges after the start edge, where `k` comes from the bench's behavioural model of the loop, including any early stop on the zero flag. `busy` is due from the first edge after start through that same cycle. The bench therefore counts edges from the start edge and compares `busy` and `done` on every falling edge, so that a phase that is one cycle too long or too short shows up as a miscompare. The final indexes, count, flags, memory image and number of reads and writes are compared one cycle after `done`, when the engine is idle and its outputs are stable.

// File: rtl/rse_pkg.sv
package rse_pkg;
  localparam int ELEM_W = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    OP_MOVE = 2'd0,
    OP_CMP  = 2'd1,
    OP_SCAN = 2'd2,
    OP_MOV2 = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    RP_ALWAYS   = 2'd0,
    RP_WHILE_EQ = 2'd1,
    RP_WHILE_NE = 2'd2,
    RP_ALWAYS2  = 2'd3
  } rep_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_RD_SRC, ST_WR_DST, ST_RD_DST, ST_UPD, ST_DONE
  } state_e;

  typedef struct packed {
    logic zf;
    logic sf;
    logic cf;
    logic of;
  } flags_t;

  // width of a phase counter able to hold the longest phase length
  function automatic int phase_w(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return $clog2(m + 1);
  endfunction
endpackage

// File: rtl/rse_seq.sv
// Phase sequencer: state register plus a per-phase cycle counter.
// RD_CYC must be at least 2 (read data is captured in the second cycle);
// UPD_CYC must be at least 2 (the stop decision uses the updated registers).
module rse_seq
  import rse_pkg::*;
#(
  parameter int SETUP_CYC = 8,
  parameter int RD_CYC    = 3,
  parameter int XF_CYC    = 3,
  parameter int UPD_CYC   = 2,
  localparam int PW = phase_w(SETUP_CYC, RD_CYC, XF_CYC, UPD_CYC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          is_move,
  input  logic          cnt_empty,
  input  logic          stop,
  output state_e        state,
  output logic [PW-1:0] ph_idx
);
  state_e        state_d;
  logic [PW-1:0] ph_len;
  logic [PW-1:0] ph_idx_d;
  logic          ph_last;

  always_comb begin
    case (state)
      ST_SETUP:  ph_len = PW'(SETUP_CYC);
      ST_RD_SRC: ph_len = PW'(RD_CYC);
      ST_WR_DST,
      ST_RD_DST: ph_len = PW'(XF_CYC);
      ST_UPD:    ph_len = PW'(UPD_CYC);
      default:   ph_len = PW'(1);
    endcase
  end

  assign ph_last = (ph_idx == ph_len - PW'(1));

  always_comb begin
    state_d = state;
    case (state)
      ST_IDLE:   if (start) state_d = ST_SETUP;
      ST_SETUP:  if (ph_last) state_d = cnt_empty ? ST_DONE : ST_RD_SRC;
      ST_RD_SRC: if (ph_last) state_d = is_move ? ST_WR_DST : ST_RD_DST;
      ST_WR_DST,
      ST_RD_DST: if (ph_last) state_d = ST_UPD;
      ST_UPD:    if (ph_last) state_d = stop ? ST_DONE : ST_RD_SRC;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    if (state_d != state) ph_idx_d = '0;
    else if (ph_last)     ph_idx_d = ph_idx;
    else                  ph_idx_d = ph_idx + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      ph_idx <= '0;
    end else begin
      state  <= state_d;
      ph_idx <= ph_idx_d;
    end
  end
endmodule

// File: rtl/rse_alu.sv
// Flag generator: a - b at byte or word width, result discarded.
module rse_alu
  import rse_pkg::*;
(
  input  logic [ELEM_W-1:0] a,
  input  logic [ELEM_W-1:0] b,
  input  logic              wide,
  output flags_t            fl
);
  logic [ELEM_W:0] dw;
  logic [BYTE_W:0] db;

  assign dw = {1'b0, a} - {1'b0, b};
  assign db = {1'b0, a[BYTE_W-1:0]} - {1'b0, b[BYTE_W-1:0]};

  always_comb begin
    if (wide) begin
      fl.zf = (dw[ELEM_W-1:0] == '0);
      fl.sf = dw[ELEM_W-1];
      fl.cf = dw[ELEM_W];
      fl.of = (a[ELEM_W-1] ^ b[ELEM_W-1]) & (dw[ELEM_W-1] ^ a[ELEM_W-1]);
    end else begin
      fl.zf = (db[BYTE_W-1:0] == '0);
      fl.sf = db[BYTE_W-1];
      fl.cf = db[BYTE_W];
      fl.of = (a[BYTE_W-1] ^ b[BYTE_W-1]) & (db[BYTE_W-1] ^ a[BYTE_W-1]);
    end
  end
endmodule

// File: rtl/rse_step.sv
// Index stepper: +/-1 for bytes, +/-2 for words.
module rse_step #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] idx,
  input  logic          dir,
  input  logic          wide,
  output logic [AW-1:0] nxt
);
  logic [AW-1:0] step;

  assign step = wide ? AW'(2) : AW'(1);
  assign nxt  = dir ? (idx - step) : (idx + step);
endmodule

// File: rtl/rep_str_engine.sv
module rep_str_engine
  import rse_pkg::*;
#(
  parameter int AW        = 16,
  parameter int CW        = 16,
  parameter int SETUP_CYC = 8,
  parameter int RD_CYC    = 3,
  parameter int XF_CYC    = 3,
  parameter int UPD_CYC   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:0]     src_idx_i,
  input  logic [AW-1:0]     dst_idx_i,
  input  logic [CW-1:0]     cnt_i,
  input  logic              dir_i,
  input  logic              wide_i,
  input  logic [1:0]        op_i,
  input  logic [1:0]        rep_i,
  input  logic [ELEM_W-1:0] acc_i,
  output logic              busy,
  output logic              done,
  output logic [AW-1:0]     src_idx_o,
  output logic [AW-1:0]     dst_idx_o,
  output logic [CW-1:0]     cnt_o,
  output logic              zf_o,
  output logic              sf_o,
  output logic              cf_o,
  output logic              of_o,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              mem_wide,
  output logic [AW-1:0]     mem_addr,
  output logic [ELEM_W-1:0] mem_wdata,
  input  logic [ELEM_W-1:0] mem_rdata
);
  localparam int PW = phase_w(SETUP_CYC, RD_CYC, XF_CYC, UPD_CYC);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  state_e            state;
  logic [PW-1:0]     ph_idx;
  logic [AW-1:0]     src_q, dst_q, src_nx, dst_nx;
  logic [CW-1:0]     cnt_q;
  logic              dir_q, wide_q;
  op_e               op_q;
  rep_e              rep_q;
  logic [ELEM_W-1:0] acc_q, src_val, dst_val, opa;
  flags_t            fl_q, fl_d;
  logic              is_move, is_scan, go, upd_en, cap_src, cap_dst, stop;

  assign is_move = (op_q == OP_MOVE) || (op_q == OP_MOV2);
  assign is_scan = (op_q == OP_SCAN);
  assign go      = (state == ST_IDLE) && start;
  assign upd_en  = (state == ST_UPD) && (ph_idx == '0);
  assign cap_src = (state == ST_RD_SRC) && (ph_idx == PW'(1)) && !is_scan;
  assign cap_dst = (state == ST_RD_DST) && (ph_idx == PW'(1));

  // early-exit decision, evaluated after the update cycle
  always_comb begin
    stop = (cnt_q == '0);
    if (!is_move) begin
      if (rep_q == RP_WHILE_EQ && !fl_q.zf) stop = 1'b1;
      if (rep_q == RP_WHILE_NE &&  fl_q.zf) stop = 1'b1;
    end
  end

  rse_seq #(
    .SETUP_CYC(SETUP_CYC), .RD_CYC(RD_CYC), .XF_CYC(XF_CYC), .UPD_CYC(UPD_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_i_n), .start(start), .is_move(is_move),
    .cnt_empty(cnt_q == '0), .stop(stop), .state(state), .ph_idx(ph_idx)
  );

  rse_step #(.AW(AW)) u_step_src (.idx(src_q), .dir(dir_q), .wide(wide_q), .nxt(src_nx));
  rse_step #(.AW(AW)) u_step_dst (.idx(dst_q), .dir(dir_q), .wide(wide_q), .nxt(dst_nx));

  assign opa = is_scan ? acc_q : src_val;
  rse_alu u_alu (.a(opa), .b(dst_val), .wide(wide_q), .fl(fl_d));

  // run configuration, captured at start
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      dir_q  <= 1'b0;
      wide_q <= 1'b0;
      op_q   <= OP_MOVE;
      rep_q  <= RP_ALWAYS;
      acc_q  <= '0;
    end else if (go) begin
      dir_q  <= dir_i;
      wide_q <= wide_i;
      op_q   <= op_e'(op_i);
      rep_q  <= rep_e'(rep_i);
      acc_q  <= acc_i;
    end
  end

  // pointers and count
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
    end else if (go) begin
      src_q <= src_idx_i;
      dst_q <= dst_idx_i;
      cnt_q <= cnt_i;
    end else if (upd_en) begin
      if (!is_scan) src_q <= src_nx;
      dst_q <= dst_nx;
      cnt_q <= cnt_q - CW'(1);
    end
  end

  // element latches
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)     src_val <= '0;
    else if (cap_src) src_val <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)     dst_val <= '0;
    else if (cap_dst) dst_val <= mem_rdata;
  end

  // flags change only on compare / scan elements
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)                fl_q <= '0;
    else if (upd_en && !is_move) fl_q <= fl_d;
  end

  assign mem_rd    = ((state == ST_RD_SRC) && (ph_idx == '0) && !is_scan) ||
                     ((state == ST_RD_DST) && (ph_idx == '0));
  assign mem_wr    = (state == ST_WR_DST) && (ph_idx == '0);
  assign mem_addr  = (state == ST_RD_SRC) ? src_q : dst_q;
  assign mem_wide  = wide_q;
  assign mem_wdata = wide_q ? src_val : {{(ELEM_W-BYTE_W){1'b0}}, src_val[BYTE_W-1:0]};

  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_DONE);
  assign src_idx_o = src_q;
  assign dst_idx_o = dst_q;
  assign cnt_o     = cnt_q;
  assign zf_o      = fl_q.zf;
  assign sf_o      = fl_q.sf;
  assign cf_o      = fl_q.cf;
  assign of_o      = fl_q.of;
endmodule

// File: rtl/rse_chk.sv
module rse_chk #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [1:0]    op_q,
  input logic [CW-1:0] cnt,
  input logic [AW-1:0] src_idx,
  input logic [AW-1:0] dst_idx
);
  logic          busy_prev;
  logic [CW-1:0] cnt_prev;
  logic [AW-1:0] src_prev, dst_prev;
  logic [CW-1:0] cnt_less;
  logic [AW-1:0] d_src, d_dst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_prev <= 1'b0;
      cnt_prev  <= '0;
      src_prev  <= '0;
      dst_prev  <= '0;
    end else begin
      busy_prev <= busy;
      cnt_prev  <= cnt;
      src_prev  <= src_idx;
      dst_prev  <= dst_idx;
    end
  end

  assign cnt_less = cnt_prev - CW'(1);
  assign d_src    = src_idx - src_prev;
  assign d_dst    = dst_idx - dst_prev;

  p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && busy_prev && cnt != cnt_prev) |-> cnt == cnt_less);

  p_src_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && busy_prev && d_src != '0) |->
      (d_src == AW'(1) || d_src == AW'(2) || d_src == '1 || d_src == AW'(-2)));

  p_dst_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && busy_prev && d_dst != '0) |->
      (d_dst == AW'(1) || d_dst == AW'(2) || d_dst == '1 || d_dst == AW'(-2)));

  p_rw_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  p_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (op_q == 2'd1 || op_q == 2'd2)) |-> !mem_wr);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd && !mem_wr));
endmodule

bind rep_str_engine rse_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .op_q(op_q),
  .cnt(cnt_o), .src_idx(src_idx_o), .dst_idx(dst_idx_o)
);

// File: tb/sim_rep_str_engine.sv
module sim_rep_str_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] src_i = '0, dst_i = '0, cnt_i = '0, acc_i = '0;
  logic        dir_i = 1'b0, wide_i = 1'b0;
  logic [1:0]  op_i = '0, rep_i = '0;
  logic        busy, done, zf, sf, cf, of, mem_rd, mem_wr, mem_wide;
  logic [15:0] src_o, dst_o, cnt_o, mem_addr, mem_wdata;
  logic [15:0] mem_rdata = '0;

  logic [7:0] mem  [0:255];
  logic [7:0] refm [0:255];
  int vec = 0, bad = 0;
  bit ezf = 0, esf = 0, ecf = 0, eof = 0;

  always #2 clk = ~clk;

  rep_str_engine u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .src_idx_i(src_i), .dst_idx_i(dst_i),
    .cnt_i(cnt_i), .dir_i(dir_i), .wide_i(wide_i), .op_i(op_i), .rep_i(rep_i),
    .acc_i(acc_i), .busy(busy), .done(done), .src_idx_o(src_o), .dst_idx_o(dst_o),
    .cnt_o(cnt_o), .zf_o(zf), .sf_o(sf), .cf_o(cf), .of_o(of), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wide(mem_wide), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  // one-cycle synchronous memory, 256 bytes, low byte first
  always @(posedge clk) begin
    if (mem_rd)
      mem_rdata <= mem_wide ? {mem[8'(mem_addr[7:0] + 8'd1)], mem[mem_addr[7:0]]}
                            : {8'h00, mem[mem_addr[7:0]]};
    if (mem_wr) begin
      mem[mem_addr[7:0]] <= mem_wdata[7:0];
      if (mem_wide) mem[8'(mem_addr[7:0] + 8'd1)] <= mem_wdata[15:8];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int rdm(input int adr, input bit wd);
    int a0 = adr & 255;
    return wd ? (int'(refm[a0]) | (int'(refm[(a0 + 1) & 255]) << 8)) : int'(refm[a0]);
  endfunction

  function automatic logic [3:0] calc(input int a, input int b, input bit wd);
    int w   = wd ? 16 : 8;
    int msk = (1 << w) - 1;
    int aa  = a & msk;
    int bb  = b & msk;
    int df  = (aa - bb) & msk;
    bit s   = ((df >> (w - 1)) & 1) != 0;
    bit as_ = ((aa >> (w - 1)) & 1) != 0;
    bit bs  = ((bb >> (w - 1)) & 1) != 0;
    return {df == 0, s, aa < bb, (as_ != bs) && (s != as_)};
  endfunction

  task automatic run(input string name, input int s, input int d, input int c,
                     input bit dr, input bit wd, input int op, input int rp,
                     input int acc, input bit poke);
    int es = s, ed = d, ec = c, k = 0, t, nrd = 0, nwr = 0, st, mism = 0;
    bit mv = (op == 0 || op == 3);
    bit sc = (op == 2);
    logic [3:0] f;
    @(negedge clk);
    for (int i = 0; i < 256; i++) refm[i] = mem[i];
    st = wd ? 2 : 1;
    // behavioural reference for the whole loop
    while (ec != 0) begin
      if (mv) begin
        int v = rdm(es, wd);
        refm[ed & 255] = 8'(v);
        if (wd) refm[(ed + 1) & 255] = 8'(v >> 8);
      end else begin
        f = calc(sc ? acc : rdm(es, wd), rdm(ed, wd), wd);
        {ezf, esf, ecf, eof} = f;
      end
      ec--;
      if (!sc) es = (dr ? es - st : es + st) & 16'hFFFF;
      ed = (dr ? ed - st : ed + st) & 16'hFFFF;
      k++;
      if (!mv && rp == 1 && !ezf) break;
      if (!mv && rp == 2 &&  ezf) break;
    end
    t = 8 + 8 * k;
    src_i = 16'(s); dst_i = 16'(d); cnt_i = 16'(c); dir_i = dr; wide_i = wd;
    op_i = 2'(op); rep_i = 2'(rp); acc_i = 16'(acc); start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int e = 0; e <= t + 1; e++) begin
      if (poke && e == 3) begin start = 1'b1; src_i = src_i ^ 16'h55; cnt_i = 16'd1; end
      if (poke && e == 4) begin start = 1'b0; src_i = 16'(s); cnt_i = 16'(c); end
      chk({name, " R8 busy"}, busy, e <= t);
      chk({name, " R8 done"}, done, e == t);
      if (mem_rd) nrd++;
      if (mem_wr) nwr++;
      @(negedge clk);
    end
    chk({name, " R1 count"}, cnt_o, 16'(ec));
    chk({name, " R2 src idx"}, src_o, 16'(es));
    chk({name, " R2 dst idx"}, dst_o, 16'(ed));
    chk({name, " R4 flags zf,sf,cf,of"}, {zf, sf, cf, of}, {ezf, esf, ecf, eof});
    for (int i = 0; i < 256; i++) if (mem[i] !== refm[i]) mism++;
    chk({name, " R3 memory image mismatches"}, mism, 0);
    chk({name, " R5 read count"}, nrd, mv ? k : (sc ? k : 2 * k));
    chk({name, " R4 write count"}, nwr, mv ? k : 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 5 + 1);
    repeat (4) @(negedge clk);
    // R11 reset state
    chk("R11 busy in reset", busy, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 busy", busy, 0);
    chk("R11 done", done, 0);
    chk("R11 flags", {zf, sf, cf, of}, 4'h0);
    chk("R11 mem request", {mem_rd, mem_wr}, 2'b00);

    // R3 R2 byte move upward
    run("move byte up", 16'h10, 16'h40, 5, 0, 0, 0, 0, 0, 0);
    // R3 R2 word move downward
    run("move word down", 16'h30, 16'hA0, 4, 1, 1, 3, 1, 0, 0);

    // R6 compare while equal, mismatch at fourth element
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      mem[8'h10 + i] <= 8'(8'h20 + i);
      mem[8'h40 + i] <= (i == 3) ? 8'h99 : 8'(8'h20 + i);
    end
    run("cmp while-eq R6", 16'h10, 16'h40, 8, 0, 0, 1, 1, 0, 0);

    // R7 R5 scan while not equal, hit at third element
    @(negedge clk);
    for (int i = 0; i < 6; i++) mem[8'h60 + i] <= (i == 2) ? 8'h5A : 8'(i);
    run("scan while-ne R7", 16'h05, 16'h60, 6, 0, 0, 2, 2, 16'h005A, 0);

    // R5 R6 word scan while equal, all match, downward
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      mem[8'h90 - 2 * i] <= 8'h34;
      mem[8'h91 - 2 * i] <= 8'h12;
    end
    run("scan word while-eq R5", 16'h07, 16'h90, 3, 1, 1, 2, 1, 16'h1234, 0);

    // R4 unconditional compare, last element gives signed overflow
    @(negedge clk);
    mem[8'h20] <= 8'h05; mem[8'h28] <= 8'h05;
    mem[8'h21] <= 8'h10; mem[8'h29] <= 8'h20;
    mem[8'h22] <= 8'h80; mem[8'h2A] <= 8'h01;
    run("cmp always R4", 16'h20, 16'h28, 3, 0, 0, 1, 0, 0, 0);

    // R9 zero count, R6 move keeps flags
    run("zero count R9", 16'h11, 16'h22, 0, 0, 0, 0, 0, 0, 0);
    // R10 start pulse during a run is ignored
    run("start while busy R10", 16'h50, 16'h70, 2, 0, 0, 0, 2, 0, 1);
    // R8 100-byte move takes 808 cycles
    run("move 100 R8", 16'h00, 16'h80, 100, 0, 0, 0, 0, 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    vec++;
    bad++;
    $display("FAIL watchdog R8 act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule